// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's execute stage and decides, each cycle, whether the core enters a handler. A pending synchronous exception code and a hardware interrupt request arrive together with the request's vector and priority level from an external controller. The block picks one of them, or neither, and performs the whole entry sequence in a single clock edge.

On entry it saves the status register, the program counter and the stack register into shadow registers and raises the privilege bits in the status register. It computes the handler address from a vector base input and the class of the event. It also records the event code in an exception-event or interrupt-event register. When the core is already inside a handler (the block bit is set), exceptions are promoted to a reset and interrupts are held off unless the core is sleeping. A saved PC that points into a branch delay slot is wound back so that the branch runs again.

Everything the core must load after the edge appears on the outputs together with a one-cycle `taken_o` pulse. The core copies `pc_o` and `sr_o` on that pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an acceptable interrupt are both pending in the same cycle, the exception is taken and the interrupt-event output keeps its previous value.
- R2: With the block bit (status bit 28) set, a pending exception with a code other than 0x1E0 is recorded as code 0x000 and routed to the reset address. Code 0x1E0 keeps its own code and routing.
- R3: With the block bit set and `sleep_i` low, an interrupt request causes no entry. With the block bit set and `sleep_i` high, the interrupt is accepted as usual.
- R4: An interrupt is accepted only if its level is strictly greater than the 4-bit mask in status bits [7:4]. Otherwise there is no entry.
- R5: `taken_o` is high for exactly the one cycle after the accepting edge. In that cycle the saved-status, saved-PC and saved-stack outputs hold the status register, PC and register-15 values from the accepting cycle. After reset all outputs are zero.
- R6: The new status register is the old one with bits 28 (block), 29 (bank) and 30 (privileged mode) set.
- R7: When `dslot_i` is high at acceptance, the saved PC is the input PC minus 2, and `dslot_clr_o` pulses together with `taken_o`.
- R8: Exception codes 0x000, 0x020 and 0x140 jump to 0xA0000000, clear status bit 15 (FPU disable) and set status bits [7:4] to 0xF.
- R9: Exception codes 0x040 and 0x060 jump to vector base + 0x400. All other exceptions, except those under R8, jump to vector base + 0x100.
- R10: Exception code 0x160 adds 2 to the saved PC. The R7 rewind is applied as well if a delay slot is flagged.
- R11: An accepted interrupt writes its vector to `irq_event_o` and jumps to vector base + 0x600. An exception writes its code to `exc_event_o` and leaves `irq_event_o` unchanged.
- R12: `wake_o` pulses in the cycle after any event that gets past the block-bit check. This includes an interrupt that the level check then rejects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_pend_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | Interrupt request from the controller |
| irq_vec_i | input | 12 | Interrupt vector code |
| irq_lvl_i | input | LVL_W | Interrupt priority level |
| sr_i | input | XLEN | Current status register |
| vec_base_i | input | XLEN | Vector base address |
| pc_i | input | XLEN | PC of the interrupted instruction |
| r15_i | input | XLEN | Current stack register value |
| dslot_i | input | 1 | Interrupted instruction sits in a delay slot |
| sleep_i | input | 1 | Core is in the sleep state |
| taken_o | output | 1 | One-cycle entry pulse |
| pc_o | output | XLEN | Handler address |
| sr_o | output | XLEN | Status register value for the handler |
| saved_sr_o | output | XLEN | Saved status register |
| saved_pc_o | output | XLEN | Saved return PC |
| saved_sp_o | output | XLEN | Saved stack register |
| exc_event_o | output | 12 | Last exception code taken |
| irq_event_o | output | 12 | Last interrupt vector taken |
| dslot_clr_o | output | 1 | Delay-slot flags are to be cleared |
| wake_o | output | 1 | Core leaves the sleep state |

## Verification
An exception and an interrupt request can arrive in the same cycle. The bench provokes this with an exception together with an interrupt whose level clears the mask. It then checks that the handler address and the exception-event output follow the exception, and that the interrupt-event output still holds the previous vector. A second overlap is between masking and promotion: a block-bit-set exception must land at the reset address with code zero, while the exempt code 0x1E0 in the same state must not.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int unsigned EVT_W       = 12;
   localparam int unsigned SR_BL_BIT   = 28;
   localparam int unsigned SR_RB_BIT   = 29;
   localparam int unsigned SR_MD_BIT   = 30;
   localparam int unsigned SR_FD_BIT   = 15;
   localparam int unsigned SR_MASK_LSB = 4;

   localparam logic [EVT_W-1:0] CODE_RESET  = 12'h000;
   localparam logic [EVT_W-1:0] CODE_EXEMPT = 12'h1E0;
   localparam logic [EVT_W-1:0] CODE_TRAP   = 12'h160;

   localparam int unsigned N_RST_CODES  = 3;
   localparam int unsigned N_MISS_CODES = 2;
   localparam logic [N_RST_CODES-1:0][EVT_W-1:0]  RST_CODES  = {12'h140, 12'h020, 12'h000};
   localparam logic [N_MISS_CODES-1:0][EVT_W-1:0] MISS_CODES = {12'h060, 12'h040};

   localparam logic [31:0] RESET_PC = 32'hA000_0000;
   localparam logic [31:0] OFS_GEN  = 32'h0000_0100;
   localparam logic [31:0] OFS_MISS = 32'h0000_0400;
   localparam logic [31:0] OFS_IRQ  = 32'h0000_0600;

   typedef struct packed {
      logic             take;
      logic             is_irq;
      logic [EVT_W-1:0] code;
      logic             wake;
   } decision_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_entry_pkg::*;
#(
   parameter int unsigned LVL_W = 4
) (
   input  logic             exc_pend_i,
   input  logic [EVT_W-1:0] exc_code_i,
   input  logic             irq_req_i,
   input  logic [EVT_W-1:0] irq_vec_i,
   input  logic [LVL_W-1:0] irq_lvl_i,
   input  logic [LVL_W-1:0] mask_i,
   input  logic             block_i,
   input  logic             sleep_i,
   output decision_t        dec_o
);
   always_comb begin
      dec_o = '0;
      if (exc_pend_i) begin
         dec_o.take = 1'b1;
         dec_o.wake = 1'b1;
         dec_o.code = (block_i && exc_code_i != CODE_EXEMPT) ? CODE_RESET : exc_code_i;
      end else if (irq_req_i && (!block_i || sleep_i)) begin
         dec_o.wake = 1'b1;
         if (irq_lvl_i > mask_i) begin
            dec_o.take   = 1'b1;
            dec_o.is_irq = 1'b1;
            dec_o.code   = irq_vec_i;
         end
      end
   end
endmodule

// File: rtl/exc_target.sv
module exc_target
   import exc_entry_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned LVL_W      = 4,
   parameter int unsigned INSN_BYTES = 2
) (
   input  decision_t       dec_i,
   input  logic [XLEN-1:0] vec_base_i,
   input  logic [XLEN-1:0] sr_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            dslot_i,
   output logic [XLEN-1:0] new_pc_o,
   output logic [XLEN-1:0] new_sr_o,
   output logic [XLEN-1:0] save_pc_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [N_RST_CODES-1:0]  rst_hit;
   logic [N_MISS_CODES-1:0] miss_hit;
   logic is_rst, is_miss, is_trap;

   for (genvar g = 0; g < N_RST_CODES; g++) begin : g_rst_cmp
      assign rst_hit[g] = !dec_i.is_irq && (dec_i.code == RST_CODES[g]);
   end
   for (genvar g = 0; g < N_MISS_CODES; g++) begin : g_miss_cmp
      assign miss_hit[g] = !dec_i.is_irq && (dec_i.code == MISS_CODES[g]);
   end

   assign is_rst  = |rst_hit;
   assign is_miss = |miss_hit;
   assign is_trap = !dec_i.is_irq && (dec_i.code == CODE_TRAP);

   always_comb begin
      if (dec_i.is_irq)  new_pc_o = vec_base_i + XLEN'(OFS_IRQ);
      else if (is_rst)   new_pc_o = XLEN'(RESET_PC);
      else if (is_miss)  new_pc_o = vec_base_i + XLEN'(OFS_MISS);
      else               new_pc_o = vec_base_i + XLEN'(OFS_GEN);
   end

   always_comb begin
      save_pc_o = pc_i;
      if (dslot_i) save_pc_o = save_pc_o - STEP;
      if (is_trap) save_pc_o = save_pc_o + STEP;
   end

   always_comb begin
      new_sr_o            = sr_i;
      new_sr_o[SR_BL_BIT] = 1'b1;
      new_sr_o[SR_RB_BIT] = 1'b1;
      new_sr_o[SR_MD_BIT] = 1'b1;
      if (is_rst) begin
         new_sr_o[SR_FD_BIT]                 = 1'b0;
         new_sr_o[SR_MASK_LSB +: LVL_W] = '1;
      end
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned LVL_W      = 4,
   parameter int unsigned INSN_BYTES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             exc_pend_i,
   input  logic [EVT_W-1:0] exc_code_i,
   input  logic             irq_req_i,
   input  logic [EVT_W-1:0] irq_vec_i,
   input  logic [LVL_W-1:0] irq_lvl_i,
   input  logic [XLEN-1:0]  sr_i,
   input  logic [XLEN-1:0]  vec_base_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [XLEN-1:0]  r15_i,
   input  logic             dslot_i,
   input  logic             sleep_i,
   output logic             taken_o,
   output logic [XLEN-1:0]  pc_o,
   output logic [XLEN-1:0]  sr_o,
   output logic [XLEN-1:0]  saved_sr_o,
   output logic [XLEN-1:0]  saved_pc_o,
   output logic [XLEN-1:0]  saved_sp_o,
   output logic [EVT_W-1:0] exc_event_o,
   output logic [EVT_W-1:0] irq_event_o,
   output logic             dslot_clr_o,
   output logic             wake_o
);
   initial begin
      assert (XLEN > SR_MD_BIT && XLEN >= 32)
         else $error("XLEN too small for status layout");
      assert (SR_MASK_LSB + LVL_W <= SR_FD_BIT)
         else $error("mask field overlaps FPU-disable bit");
      assert (INSN_BYTES > 0 && INSN_BYTES <= 8)
         else $error("INSN_BYTES out of range");
   end

   decision_t       dec;
   logic [XLEN-1:0] nxt_pc, nxt_sr, nxt_save_pc;

   exc_arbiter #(.LVL_W(LVL_W)) i_arb (
      .exc_pend_i (exc_pend_i),
      .exc_code_i (exc_code_i),
      .irq_req_i  (irq_req_i),
      .irq_vec_i  (irq_vec_i),
      .irq_lvl_i  (irq_lvl_i),
      .mask_i     (sr_i[SR_MASK_LSB +: LVL_W]),
      .block_i    (sr_i[SR_BL_BIT]),
      .sleep_i    (sleep_i),
      .dec_o      (dec)
   );

   exc_target #(.XLEN(XLEN), .LVL_W(LVL_W), .INSN_BYTES(INSN_BYTES)) i_tgt (
      .dec_i      (dec),
      .vec_base_i (vec_base_i),
      .sr_i       (sr_i),
      .pc_i       (pc_i),
      .dslot_i    (dslot_i),
      .new_pc_o   (nxt_pc),
      .new_sr_o   (nxt_sr),
      .save_pc_o  (nxt_save_pc)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         taken_o     <= 1'b0;
         pc_o        <= '0;
         sr_o        <= '0;
         saved_sr_o  <= '0;
         saved_pc_o  <= '0;
         saved_sp_o  <= '0;
         exc_event_o <= '0;
         irq_event_o <= '0;
         dslot_clr_o <= 1'b0;
         wake_o      <= 1'b0;
      end else begin
         taken_o     <= dec.take;
         wake_o      <= dec.wake;
         dslot_clr_o <= dec.take && dslot_i;
         if (dec.take) begin
            pc_o       <= nxt_pc;
            sr_o       <= nxt_sr;
            saved_sr_o <= sr_i;
            saved_pc_o <= nxt_save_pc;
            saved_sp_o <= r15_i;
            if (dec.is_irq) irq_event_o <= dec.code;
            else            exc_event_o <= dec.code;
         end
      end
   end

   // R1: exception wins, interrupt-event untouched
   assert_exc_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_pend_i |=> (taken_o && $stable(irq_event_o)));

   // R2: masked exception becomes reset code
   assert_promote_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_pend_i && sr_i[SR_BL_BIT] && exc_code_i != CODE_EXEMPT)
      |=> (exc_event_o == CODE_RESET && pc_o == XLEN'(RESET_PC)));

   // R3: blocked interrupt without sleep is ignored
   assert_block_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!exc_pend_i && sr_i[SR_BL_BIT] && !sleep_i) |=> !taken_o);

   // R4: level at or below mask is ignored
   assert_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!exc_pend_i && irq_lvl_i <= sr_i[SR_MASK_LSB +: LVL_W]) |=> !taken_o);

   // R5: status saved from accepting cycle
   assert_save_sr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_pend_i |=> (saved_sr_o == $past(sr_i) && saved_sp_o == $past(r15_i)));

   // R6: privilege bits set on every entry
   assert_priv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      taken_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_MD_BIT]));

   // R7: delay-slot rewind on a non-trap exception
   assert_rewind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_pend_i && dslot_i && exc_code_i != CODE_TRAP)
      |=> (saved_pc_o == $past(pc_i) - XLEN'(INSN_BYTES) && dslot_clr_o));

   // R12: wake only after a pulse-worthy event
   assert_wake_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      taken_o |-> wake_o);
endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
   localparam int unsigned XLEN = 32;
   localparam logic [31:0] VBASE = 32'h8C00_0000;
   localparam logic [31:0] SP    = 32'h1234_5678;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        exc_pend, irq_req, dslot, sleep;
   logic [11:0] exc_code, irq_vec;
   logic [3:0]  irq_lvl;
   logic [31:0] sr, pc;
   logic        taken, dclr, wake;
   logic [31:0] pc_out, sr_out, ssr, spc, ssp;
   logic [11:0] exc_evt, irq_evt;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   exc_entry_seq i_exc_entry_seq (
      .clk_i(clk), .rst_ni(rst_n),
      .exc_pend_i(exc_pend), .exc_code_i(exc_code),
      .irq_req_i(irq_req), .irq_vec_i(irq_vec), .irq_lvl_i(irq_lvl),
      .sr_i(sr), .vec_base_i(VBASE), .pc_i(pc), .r15_i(SP),
      .dslot_i(dslot), .sleep_i(sleep),
      .taken_o(taken), .pc_o(pc_out), .sr_o(sr_out),
      .saved_sr_o(ssr), .saved_pc_o(spc), .saved_sp_o(ssp),
      .exc_event_o(exc_evt), .irq_event_o(irq_evt),
      .dslot_clr_o(dclr), .wake_o(wake)
   );

   typedef struct packed {
      logic        exc;
      logic [11:0] code;
      logic        irq;
      logic [11:0] vec;
      logic [3:0]  lvl;
      logic [31:0] sr;
      logic [31:0] pc;
      logic        ds;
      logic        slp;
      logic        e_tk;
      logic [31:0] e_pc;
      logic [31:0] e_spc;
      logic [11:0] e_evt;
      logic [3:0]  req;
   } vec_t;

   localparam int N_VEC = 14;
   localparam vec_t TBL [N_VEC] = '{
      // R9 general exception
      '{1'b1, 12'h0E0, 1'b0, 12'h000, 4'd0, 32'h0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8C00_0100, 32'h1000, 12'h0E0, 4'd9},
      // R9 miss codes
      '{1'b1, 12'h040, 1'b0, 12'h000, 4'd0, 32'h0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8C00_0400, 32'h1000, 12'h040, 4'd9},
      '{1'b1, 12'h060, 1'b0, 12'h000, 4'd0, 32'h0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8C00_0400, 32'h1000, 12'h060, 4'd9},
      // R8 reset class
      '{1'b1, 12'h020, 1'b0, 12'h000, 4'd0, 32'h0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'hA000_0000, 32'h1000, 12'h020, 4'd8},
      // R10 trap
      '{1'b1, 12'h160, 1'b0, 12'h000, 4'd0, 32'h0, 32'h2000, 1'b0, 1'b0, 1'b1, 32'h8C00_0100, 32'h2002, 12'h160, 4'd10},
      '{1'b1, 12'h160, 1'b0, 12'h000, 4'd0, 32'h0, 32'h2000, 1'b1, 1'b0, 1'b1, 32'h8C00_0100, 32'h2000, 12'h160, 4'd10},
      // R7 delay-slot rewind
      '{1'b1, 12'h0A0, 1'b0, 12'h000, 4'd0, 32'h0, 32'h3000, 1'b1, 1'b0, 1'b1, 32'h8C00_0100, 32'h2FFE, 12'h0A0, 4'd7},
      // R11 interrupt accepted
      '{1'b0, 12'h000, 1'b1, 12'h3C0, 4'd5, 32'h30, 32'h5000, 1'b0, 1'b0, 1'b1, 32'h8C00_0600, 32'h5000, 12'h3C0, 4'd11},
      // R4 level equal to mask
      '{1'b0, 12'h000, 1'b1, 12'h3C0, 4'd3, 32'h30, 32'h5000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 12'h0, 4'd4},
      // R1 both pending
      '{1'b1, 12'h100, 1'b1, 12'h3C0, 4'd9, 32'h0, 32'h6000, 1'b0, 1'b0, 1'b1, 32'h8C00_0100, 32'h6000, 12'h100, 4'd1},
      // R2 promotion and exempt code
      '{1'b1, 12'h0E0, 1'b0, 12'h000, 4'd0, 32'h1000_0000, 32'h7000, 1'b0, 1'b0, 1'b1, 32'hA000_0000, 32'h7000, 12'h000, 4'd2},
      '{1'b1, 12'h1E0, 1'b0, 12'h000, 4'd0, 32'h1000_0000, 32'h7000, 1'b0, 1'b0, 1'b1, 32'h8C00_0100, 32'h7000, 12'h1E0, 4'd2},
      // R3 blocked interrupt, awake then sleeping
      '{1'b0, 12'h000, 1'b1, 12'h200, 4'd9, 32'h1000_0000, 32'h7000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 12'h0, 4'd3},
      '{1'b0, 12'h000, 1'b1, 12'h200, 4'd9, 32'h1000_0000, 32'h7000, 1'b0, 1'b1, 1'b1, 32'h8C00_0600, 32'h7000, 12'h200, 4'd3}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      exc_pend = 1'b0; irq_req = 1'b0; dslot = 1'b0; sleep = 1'b0;
      exc_code = '0; irq_vec = '0; irq_lvl = '0; sr = '0; pc = '0;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R5 reset state
      chk("R5 reset taken", {31'b0, taken}, 32'h0);
      chk("R5 reset pc", pc_out, 32'h0);
      chk("R5 reset evt", {20'b0, exc_evt}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < N_VEC; i++) begin
         @(negedge clk);
         exc_pend = TBL[i].exc; exc_code = TBL[i].code;
         irq_req = TBL[i].irq; irq_vec = TBL[i].vec; irq_lvl = TBL[i].lvl;
         sr = TBL[i].sr; pc = TBL[i].pc; dslot = TBL[i].ds; sleep = TBL[i].slp;
         step();
         chk($sformatf("R%0d row %0d taken", TBL[i].req, i), {31'b0, taken}, {31'b0, TBL[i].e_tk});
         if (TBL[i].e_tk) begin
            chk($sformatf("R%0d row %0d pc", TBL[i].req, i), pc_out, TBL[i].e_pc);
            chk($sformatf("R%0d row %0d saved pc", TBL[i].req, i), spc, TBL[i].e_spc);
            if (TBL[i].exc)
               chk($sformatf("R%0d row %0d exc event", TBL[i].req, i), {20'b0, exc_evt}, {20'b0, TBL[i].e_evt});
            else
               chk($sformatf("R%0d row %0d irq event", TBL[i].req, i), {20'b0, irq_evt}, {20'b0, TBL[i].e_evt});
         end
         idle();
      end

      // R5 R6 shadow copies and privilege bits
      @(negedge clk);
      exc_pend = 1'b1; exc_code = 12'h0E0; sr = 32'h0000_0055; pc = 32'h4000;
      step();
      chk("R5 saved sr", ssr, 32'h0000_0055);
      chk("R5 saved sp", ssp, SP);
      chk("R6 new sr", sr_out, 32'h7000_0055);
      chk("R7 no dslot clear", {31'b0, dclr}, 32'h0);
      idle();
      step();
      chk("R5 pulse ends", {31'b0, taken}, 32'h0);

      // R8 status effects of reset class
      @(negedge clk);
      exc_pend = 1'b1; exc_code = 12'h140; sr = 32'h0000_8030; pc = 32'h4100;
      step();
      chk("R8 pc", pc_out, 32'hA000_0000);
      chk("R8 sr", sr_out, 32'h7000_00F0);
      idle();

      // R7 delay-slot clear pulse
      @(negedge clk);
      exc_pend = 1'b1; exc_code = 12'h0E0; dslot = 1'b1; pc = 32'h4200;
      step();
      chk("R7 dslot clear", {31'b0, dclr}, 32'h1);
      chk("R7 saved pc", spc, 32'h41FE);
      idle();

      // R11 exception keeps interrupt event
      @(negedge clk);
      irq_req = 1'b1; irq_vec = 12'h5A0; irq_lvl = 4'd15;
      step();
      chk("R11 irq event", {20'b0, irq_evt}, 32'h5A0);
      idle();
      @(negedge clk);
      exc_pend = 1'b1; exc_code = 12'h180;
      step();
      chk("R11 irq event kept", {20'b0, irq_evt}, 32'h5A0);
      chk("R11 exc event", {20'b0, exc_evt}, 32'h180);
      idle();

      // R12 wake on level-rejected interrupt, none when blocked
      @(negedge clk);
      irq_req = 1'b1; irq_lvl = 4'd2; sr = 32'h0000_0050;
      step();
      chk("R12 wake", {31'b0, wake}, 32'h1);
      chk("R12 not taken", {31'b0, taken}, 32'h0);
      idle();
      @(negedge clk);
      irq_req = 1'b1; irq_lvl = 4'd9; sr = 32'h1000_0000;
      step();
      chk("R12 no wake", {31'b0, wake}, 32'h0);
      idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule